// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns the post-byte of an indexed-addressing instruction into a 16-bit effective address for an 8-bit processor with four 16-bit index registers. The core pulses `start` with the post-byte and a snapshot of its registers. The block then pulls any offset bytes it needs from the instruction stream over a byte handshake. For indirect forms it reads a 16-bit pointer one byte at a time over a memory read port. When it is finished it pulses `done`, and at that point the address, the extra-cycle cost and an illegal-encoding flag are valid.

The auto-increment and auto-decrement forms change the selected index register. The block reports the new value on a one-cycle write strobe right after `start`. A write to the stack-pointer register also raises a strobe that arms the non-maskable interrupt. All register values are captured in the `start` cycle. The core may therefore apply the write-back at once without disturbing the address being computed.

Top module: `idx_ea_gen`

## Requirements
- R1: With post-byte bit 7 clear, bits 4..0 are a signed offset (-16..+15) added to the register chosen by bits 6..5 (00 X, 01 Y, 10 U, 11 S). There is no fetch and no indirection, and the extra cost is 1.
- R2: With bit 7 set, bits 3..0 give the mode and bit 4 the indirect flag. Modes 0 and 1 use the register as the address and write back the register plus 1 (cost 2) or plus 2 (cost 3).
- R3: Modes 2 and 3 subtract 1 (cost 2) or 2 (cost 3) from the register. The result is both the address and the written-back value.
- R4: Mode 4 uses the register unchanged (cost 0). Mode 6 adds sign-extended A and mode 5 adds sign-extended B (cost 1 each). Mode 11 adds the 16-bit D (cost 4).
- R5: Mode 8 fetches one byte and adds it sign-extended (cost 1). Mode 9 fetches two bytes, high byte first, and adds the 16-bit value (cost 4).
- R6: Modes 12 (one byte, cost 1) and 13 (two bytes, cost 4 plus 1, so 5) add the fetched offset to `reg_pc` plus the number of bytes fetched. `reg_pc` is the address of the byte after the post-byte.
- R7: With the indirect flag set, the computed address locates a pointer. The block reads its high byte at that address and its low byte at the address plus 1, and adds 3 to the cost.
- R8: Mode 15 with the flag set fetches a two-byte absolute address, ignores bits 6..5 and returns the pointer stored there, at a total cost of 5.
- R9: Modes 7, 10, 14 and 15 without the flag return address 0, cost 0 and `illegal`=1, and they make no fetch, read or write. The flag set on mode 0 or 2 also sets `illegal`, but the access is still done as an indirect one.
- R10: `reg_wr_en` is a one-cycle pulse in the cycle after `start`, with `reg_wr_sel` coded as in R1. `nmi_arm` pulses with it exactly when the target is S.
- R11: A byte is consumed only in a cycle where the request and its ack are both high. A request stays up, with its address unchanged, until it is acknowledged.
- R12: `done` is a one-cycle pulse. Forms with no fetch and no read reach `done` in the cycle after `start`. `start` is ignored while `busy`.
- R13: While reset is held, `busy`, `done`, both requests and `reg_wr_en` are low.
- R14: All address and write-back arithmetic wraps modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `post_byte` (accepted when idle) |
| post_byte | input | 8 | Indexed-mode post-byte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_u | input | 16 | User stack pointer U |
| reg_s | input | 16 | System stack pointer S |
| reg_pc | input | 16 | Address of the byte after the post-byte |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Double accumulator D |
| fetch_req | output | 1 | Request for the next instruction-stream byte |
| fetch_ack | input | 1 | Instruction byte presented |
| fetch_data | input | 8 | Instruction byte |
| mem_rd_req | output | 1 | Pointer byte read request |
| mem_rd_addr | output | 16 | Pointer byte address |
| mem_rd_ack | input | 1 | Read data presented |
| mem_rd_data | input | 8 | Read data |
| reg_wr_en | output | 1 | Index register write-back strobe |
| reg_wr_sel | output | 2 | Register to write (00 X, 01 Y, 10 U, 11 S) |
| reg_wr_data | output | 16 | Value to write back |
| nmi_arm | output | 1 | Pulse arming the non-maskable interrupt after an S write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid this cycle |
| ea | output | 16 | Effective address |
| extra_cyc | output | 4 | Extra cycles charged by the mode |
| illegal | output | 1 | Undefined or irregular encoding seen |

## Verification
The properties assume that the core raises `start` only while `busy` is low, except where the deliberate ignored-start case applies. They also assume that an ack carries valid data whenever its request is high. The stimulus lowers both acks on alternate cycles, so every request is seen waiting as well as being served at once. Memory answers every read with the inverted low byte of the address. The bench can therefore predict each pointer byte, including a read that wraps from 0xFFFF to 0x0000. Register values are held constant across an operation, apart from the two directed wrap cases, which change X between operations.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    localparam int unsigned EXTRA_W  = 4;
    localparam int unsigned IND_COST = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        OFS_NONE,
        OFS_SHORT,
        OFS_ACC_A,
        OFS_ACC_B,
        OFS_ACC_D
    } ofs_kind_e;

    localparam logic [1:0] SEL_S = 2'b11;

    typedef struct packed {
        logic [1:0]         sel;
        logic               undef;
        logic               flag_ill;
        logic               indirect;
        logic [1:0]         nfetch;
        logic               use_pc;
        logic               abs_base;
        logic               step_en;
        logic               step_dec;
        logic [1:0]         step_amt;
        ofs_kind_e          ofs;
        logic [EXTRA_W-1:0] extra;
    } post_info_t;

endpackage

// File: rtl/idx_post_decode.sv
module idx_post_decode
    import idx_ea_pkg::*;
(
    input  logic [7:0]  post,
    output post_info_t  info
);

    logic       ind_bit;
    logic [3:0] mode;
    logic       undef_w;

    assign ind_bit = post[4];
    assign mode    = post[3:0];

    always_comb begin
        info     = '0;
        info.sel = post[6:5];
        info.ofs = OFS_NONE;
        undef_w  = 1'b0;
        if (!post[7]) begin
            info.ofs   = OFS_SHORT;
            info.extra = EXTRA_W'(1);
        end else begin
            unique case (mode)
                4'h0: begin
                    info.step_en  = 1'b1;
                    info.step_amt = 2'd1;
                    info.extra    = EXTRA_W'(2);
                    info.flag_ill = ind_bit;
                end
                4'h1: begin
                    info.step_en  = 1'b1;
                    info.step_amt = 2'd2;
                    info.extra    = EXTRA_W'(3);
                end
                4'h2: begin
                    info.step_en  = 1'b1;
                    info.step_dec = 1'b1;
                    info.step_amt = 2'd1;
                    info.extra    = EXTRA_W'(2);
                    info.flag_ill = ind_bit;
                end
                4'h3: begin
                    info.step_en  = 1'b1;
                    info.step_dec = 1'b1;
                    info.step_amt = 2'd2;
                    info.extra    = EXTRA_W'(3);
                end
                4'h4: info.extra = EXTRA_W'(0);
                4'h5: begin
                    info.ofs   = OFS_ACC_B;
                    info.extra = EXTRA_W'(1);
                end
                4'h6: begin
                    info.ofs   = OFS_ACC_A;
                    info.extra = EXTRA_W'(1);
                end
                4'h8: begin
                    info.nfetch = 2'd1;
                    info.extra  = EXTRA_W'(1);
                end
                4'h9: begin
                    info.nfetch = 2'd2;
                    info.extra  = EXTRA_W'(4);
                end
                4'hB: begin
                    info.ofs   = OFS_ACC_D;
                    info.extra = EXTRA_W'(4);
                end
                4'hC: begin
                    info.use_pc = 1'b1;
                    info.nfetch = 2'd1;
                    info.extra  = EXTRA_W'(1);
                end
                4'hD: begin
                    info.use_pc = 1'b1;
                    info.nfetch = 2'd2;
                    info.extra  = EXTRA_W'(5);
                end
                4'hF: begin
                    if (ind_bit) begin
                        info.abs_base = 1'b1;
                        info.nfetch   = 2'd2;
                        info.extra    = EXTRA_W'(5);
                    end else begin
                        undef_w = 1'b1;
                    end
                end
                default: undef_w = 1'b1;
            endcase

            if (undef_w) begin
                info          = '0;
                info.sel      = post[6:5];
                info.ofs      = OFS_NONE;
                info.undef    = 1'b1;
                info.flag_ill = 1'b1;
            end else begin
                info.indirect = ind_bit;
                if (ind_bit && !info.abs_base) begin
                    info.extra = info.extra + EXTRA_W'(IND_COST);
                end
            end
        end
    end

endmodule

// File: rtl/idx_base_calc.sv
module idx_base_calc
    import idx_ea_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2 * BYTE_W
) (
    input  logic [1:0]        sel,
    input  ofs_kind_e         ofs,
    input  logic              undef,
    input  logic              abs_base,
    input  logic              use_pc,
    input  logic [1:0]        nfetch,
    input  logic              step_en,
    input  logic              step_dec,
    input  logic [1:0]        step_amt,
    input  logic [4:0]        short_ofs,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_u,
    input  logic [ADDR_W-1:0] reg_s,
    input  logic [ADDR_W-1:0] reg_pc,
    input  logic [BYTE_W-1:0] acc_a,
    input  logic [BYTE_W-1:0] acc_b,
    input  logic [ADDR_W-1:0] acc_d,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] wb_val
);

    localparam int unsigned SHORT_PAD = ADDR_W - 5;
    localparam int unsigned BYTE_PAD  = ADDR_W - BYTE_W;
    localparam int unsigned CNT_PAD   = ADDR_W - 2;

    logic [ADDR_W-1:0] reg_v;
    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] a_ext;
    logic [ADDR_W-1:0] b_ext;
    logic [ADDR_W-1:0] step_w;
    logic [ADDR_W-1:0] fetch_w;

    always_comb begin
        unique case (sel)
            2'b00:   reg_v = reg_x;
            2'b01:   reg_v = reg_y;
            2'b10:   reg_v = reg_u;
            default: reg_v = reg_s;
        endcase
    end

    assign short_ext = {{SHORT_PAD{short_ofs[4]}}, short_ofs};
    assign a_ext     = {{BYTE_PAD{acc_a[BYTE_W-1]}}, acc_a};
    assign b_ext     = {{BYTE_PAD{acc_b[BYTE_W-1]}}, acc_b};
    assign step_w    = {{CNT_PAD{1'b0}}, step_amt};
    assign fetch_w   = {{CNT_PAD{1'b0}}, nfetch};
    assign wb_val    = step_dec ? (reg_v - step_w) : (reg_v + step_w);

    always_comb begin
        unique case (ofs)
            OFS_SHORT: base = reg_v + short_ext;
            OFS_ACC_A: base = reg_v + a_ext;
            OFS_ACC_B: base = reg_v + b_ext;
            OFS_ACC_D: base = reg_v + acc_d;
            default: begin
                if (undef || abs_base) begin
                    base = '0;
                end else if (use_pc) begin
                    base = reg_pc + fetch_w;
                end else if (step_en && step_dec) begin
                    base = wb_val;
                end else begin
                    base = reg_v;
                end
            end
        endcase
    end

endmodule

// File: rtl/idx_ea_seq.sv
module idx_ea_seq
    import idx_ea_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         sel,
    input  logic               flag_ill,
    input  logic               indirect,
    input  logic [1:0]         nfetch,
    input  logic               step_en,
    input  logic [EXTRA_W-1:0] extra_in,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  wb_val,
    output logic               fetch_req,
    input  logic               fetch_ack,
    input  logic [BYTE_W-1:0]  fetch_data,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_ack,
    input  logic [BYTE_W-1:0]  mem_rd_data,
    output logic               reg_wr_en,
    output logic [1:0]         reg_wr_sel,
    output logic [ADDR_W-1:0]  reg_wr_data,
    output logic               nmi_arm,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  ea,
    output logic [EXTRA_W-1:0] extra_cyc,
    output logic               illegal
);

    localparam int unsigned BYTE_PAD = ADDR_W - BYTE_W;

    typedef struct packed {
        seq_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]  hold;
        logic [1:0]         left;
        logic               wide;
        logic               ind;
        logic               rd_lo;
        logic [EXTRA_W-1:0] extra;
        logic               ill;
        logic               wr_en;
        logic [1:0]         wr_sel;
        logic [ADDR_W-1:0]  wr_data;
        logic               nmi;
    } seq_t;

    seq_t              seq_q;
    seq_t              seq_d;
    logic [ADDR_W-1:0] ofs_word;

    assign ofs_word = seq_q.wide ? {seq_q.hold, fetch_data}
                                 : {{BYTE_PAD{fetch_data[BYTE_W-1]}}, fetch_data};

    always_comb begin
        seq_d       = seq_q;
        seq_d.wr_en = 1'b0;
        seq_d.nmi   = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.addr    = base;
                    seq_d.left    = nfetch;
                    seq_d.wide    = (nfetch == 2'd2);
                    seq_d.ind     = indirect;
                    seq_d.rd_lo   = 1'b0;
                    seq_d.extra   = extra_in;
                    seq_d.ill     = flag_ill;
                    seq_d.wr_en   = step_en;
                    seq_d.wr_sel  = sel;
                    seq_d.wr_data = wb_val;
                    seq_d.nmi     = step_en && (sel == SEL_S);
                    if (nfetch != 2'd0) begin
                        seq_d.st = ST_FETCH;
                    end else if (indirect) begin
                        seq_d.st = ST_READ;
                    end else begin
                        seq_d.st = ST_DONE;
                    end
                end
            end
            ST_FETCH: begin
                if (fetch_ack) begin
                    seq_d.hold = fetch_data;
                    seq_d.left = seq_q.left - 2'd1;
                    if (seq_q.left == 2'd1) begin
                        seq_d.addr = seq_q.addr + ofs_word;
                        seq_d.st   = seq_q.ind ? ST_READ : ST_DONE;
                    end
                end
            end
            ST_READ: begin
                if (mem_rd_ack) begin
                    if (!seq_q.rd_lo) begin
                        seq_d.hold  = mem_rd_data;
                        seq_d.rd_lo = 1'b1;
                    end else begin
                        seq_d.addr = {seq_q.hold, mem_rd_data};
                        seq_d.st   = ST_DONE;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fetch_req   = (seq_q.st == ST_FETCH);
    assign mem_rd_req  = (seq_q.st == ST_READ);
    assign mem_rd_addr = seq_q.addr + {{(ADDR_W-1){1'b0}}, seq_q.rd_lo};
    assign reg_wr_en   = seq_q.wr_en;
    assign reg_wr_sel  = seq_q.wr_sel;
    assign reg_wr_data = seq_q.wr_data;
    assign nmi_arm     = seq_q.nmi;
    assign busy        = (seq_q.st != ST_IDLE);
    assign done        = (seq_q.st == ST_DONE);
    assign ea          = seq_q.addr;
    assign extra_cyc   = seq_q.extra;
    assign illegal     = seq_q.ill;

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         post_byte,
    input  logic [ADDR_W-1:0]  reg_x,
    input  logic [ADDR_W-1:0]  reg_y,
    input  logic [ADDR_W-1:0]  reg_u,
    input  logic [ADDR_W-1:0]  reg_s,
    input  logic [ADDR_W-1:0]  reg_pc,
    input  logic [BYTE_W-1:0]  acc_a,
    input  logic [BYTE_W-1:0]  acc_b,
    input  logic [ADDR_W-1:0]  acc_d,
    output logic               fetch_req,
    input  logic               fetch_ack,
    input  logic [BYTE_W-1:0]  fetch_data,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_ack,
    input  logic [BYTE_W-1:0]  mem_rd_data,
    output logic               reg_wr_en,
    output logic [1:0]         reg_wr_sel,
    output logic [ADDR_W-1:0]  reg_wr_data,
    output logic               nmi_arm,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  ea,
    output logic [EXTRA_W-1:0] extra_cyc,
    output logic               illegal
);

    post_info_t        info;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] wb_val;

    idx_post_decode u_decode (
        .post (post_byte),
        .info (info)
    );

    idx_base_calc #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_base (
        .sel       (info.sel),
        .ofs       (info.ofs),
        .undef     (info.undef),
        .abs_base  (info.abs_base),
        .use_pc    (info.use_pc),
        .nfetch    (info.nfetch),
        .step_en   (info.step_en),
        .step_dec  (info.step_dec),
        .step_amt  (info.step_amt),
        .short_ofs (post_byte[4:0]),
        .reg_x     (reg_x),
        .reg_y     (reg_y),
        .reg_u     (reg_u),
        .reg_s     (reg_s),
        .reg_pc    (reg_pc),
        .acc_a     (acc_a),
        .acc_b     (acc_b),
        .acc_d     (acc_d),
        .base      (base),
        .wb_val    (wb_val)
    );

    idx_ea_seq #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .sel         (info.sel),
        .flag_ill    (info.flag_ill),
        .indirect    (info.indirect),
        .nfetch      (info.nfetch),
        .step_en     (info.step_en),
        .extra_in    (info.extra),
        .base        (base),
        .wb_val      (wb_val),
        .fetch_req   (fetch_req),
        .fetch_ack   (fetch_ack),
        .fetch_data  (fetch_data),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data),
        .nmi_arm     (nmi_arm),
        .busy        (busy),
        .done        (done),
        .ea          (ea),
        .extra_cyc   (extra_cyc),
        .illegal     (illegal)
    );

endmodule

// File: rtl/idx_ea_gen_props.sv
module idx_ea_gen_props
    import idx_ea_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               fetch_req,
    input logic               fetch_ack,
    input logic               mem_rd_req,
    input logic               mem_rd_ack,
    input logic [ADDR_W-1:0]  mem_rd_addr,
    input logic               reg_wr_en,
    input logic [1:0]         reg_wr_sel,
    input logic               nmi_arm,
    input logic               illegal,
    input logic [EXTRA_W-1:0] extra_cyc,
    input logic [ADDR_W-1:0]  ea
);

    // R12: result strobe lasts one cycle
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: an accepted start makes the block busy
    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: write-back strobe lasts one cycle
    assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R10: interrupt arming only with a write to S
    assert_nmi_with_s_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_arm |-> (reg_wr_en && reg_wr_sel == 2'b11));

    // R11: fetch request held until acknowledged
    assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> fetch_req);

    // R11: read request and address held until acknowledged
    assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R11: never both requests at once
    assert_req_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && mem_rd_req));

    // R9: zero-cost illegal result carries address zero
    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal && extra_cyc == '0) |-> (ea == '0));

    // R7: the largest cost is a 5-cycle mode plus indirection
    assert_cost_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (extra_cyc <= EXTRA_W'(8)));

    // R12: no requests while idle
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fetch_req && !mem_rd_req && !done));

endmodule

bind idx_ea_gen idx_ea_gen_props #(
    .ADDR_W (ADDR_W)
) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fetch_req   (fetch_req),
    .fetch_ack   (fetch_ack),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_addr (mem_rd_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .nmi_arm     (nmi_arm),
    .illegal     (illegal),
    .extra_cyc   (extra_cyc),
    .ea          (ea)
);

// File: tb/idx_ea_gen_test.sv
module idx_ea_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  post_byte = 8'h00;
    logic [15:0] reg_x = 16'h1000;
    logic [15:0] reg_y = 16'h2000;
    logic [15:0] reg_u = 16'h3000;
    logic [15:0] reg_s = 16'h4000;
    logic [15:0] reg_pc = 16'h8000;
    logic [7:0]  acc_a = 8'hF0;
    logic [7:0]  acc_b = 8'h05;
    logic [15:0] acc_d = 16'hF005;
    logic        fetch_req;
    logic        fetch_ack = 1'b0;
    logic [7:0]  fetch_data = 8'h00;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_sel;
    logic [15:0] reg_wr_data;
    logic        nmi_arm;
    logic        busy;
    logic        done;
    logic [15:0] ea;
    logic [3:0]  extra_cyc;
    logic        illegal;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    idx_ea_gen uut (
        .clk (clk), .rst_n (rst_n), .start (start), .post_byte (post_byte),
        .reg_x (reg_x), .reg_y (reg_y), .reg_u (reg_u), .reg_s (reg_s),
        .reg_pc (reg_pc), .acc_a (acc_a), .acc_b (acc_b), .acc_d (acc_d),
        .fetch_req (fetch_req), .fetch_ack (fetch_ack), .fetch_data (fetch_data),
        .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
        .mem_rd_ack (mem_rd_ack), .mem_rd_data (mem_rd_data),
        .reg_wr_en (reg_wr_en), .reg_wr_sel (reg_wr_sel),
        .reg_wr_data (reg_wr_data), .nmi_arm (nmi_arm), .busy (busy),
        .done (done), .ea (ea), .extra_cyc (extra_cyc), .illegal (illegal)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles expected below 20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Requirement a post-byte belongs to, from the encodings in the brief
    function automatic string tag_of(input logic [7:0] p);
        if (!p[7]) return "R1";
        case (p[3:0])
            4'h0, 4'h1: return p[4] ? "R7" : "R2";
            4'h2, 4'h3: return p[4] ? "R7" : "R3";
            4'h4, 4'h5, 4'h6, 4'hB: return p[4] ? "R7" : "R4";
            4'h8, 4'h9: return p[4] ? "R7" : "R5";
            4'hC, 4'hD: return p[4] ? "R7" : "R6";
            4'hF: return p[4] ? "R8" : "R9";
            default: return "R9";
        endcase
    endfunction

    // Results of one operation
    logic [15:0] r_ea;
    logic [3:0]  r_ext;
    logic        r_ill;
    logic        r_done;
    int          r_lat;
    int          r_nf;
    int          r_nr;
    int          r_wr;
    logic [1:0]  r_wsel;
    logic [15:0] r_wdata;
    logic        r_nmi;
    logic        stall = 1'b0;

    task automatic run_op(input logic [7:0] post, input logic [7:0] b0,
                          input logic [7:0] b1, input bit inject);
        @(negedge clk);
        post_byte = post;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_done = 1'b0; r_lat = -1; r_nf = 0; r_nr = 0; r_wr = 0;
        r_wsel = 2'b00; r_wdata = 16'h0; r_nmi = 1'b0;
        r_ea = 16'h0; r_ext = 4'h0; r_ill = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (inject && i == 0) begin
                start = 1'b1;
                post_byte = 8'h84;
            end else begin
                start = 1'b0;
            end
            if (reg_wr_en) begin
                r_wr++;
                r_wsel = reg_wr_sel;
                r_wdata = reg_wr_data;
                r_nmi = nmi_arm;
            end
            if (done) begin
                r_done = 1'b1; r_lat = i;
                r_ea = ea; r_ext = extra_cyc; r_ill = illegal;
                break;
            end
            stall = ~stall;
            fetch_ack = fetch_req && !stall;
            fetch_data = (r_nf == 0) ? b0 : b1;
            if (fetch_ack) r_nf++;
            mem_rd_ack = mem_rd_req && !stall;
            mem_rd_data = ~mem_rd_addr[7:0];
            if (mem_rd_ack) r_nr++;
            @(negedge clk);
        end
        start = 1'b0;
        fetch_ack = 1'b0;
        mem_rd_ack = 1'b0;
        chk("R12", "done seen", 32'(r_done), 32'd1);
        @(negedge clk);
        chk("R12", "done single pulse", 32'(done), 32'd0);
    endtask

    // post, b0, b1, ea, extra, illegal, wr, wr_sel, wr_data, nmi, fetches, reads
    localparam int NV = 26;
    localparam logic [68:0] VEC [NV] = '{
        {8'h05, 8'h00, 8'h00, 16'h1005, 4'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h3F, 8'h00, 8'h00, 16'h1FFF, 4'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h70, 8'h00, 8'h00, 16'h3FF0, 4'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h80, 8'h00, 8'h00, 16'h1000, 4'd2, 1'b0, 1'b1, 2'd0, 16'h1001, 1'b0, 2'd0, 2'd0},
        {8'hA1, 8'h00, 8'h00, 16'h2000, 4'd3, 1'b0, 1'b1, 2'd1, 16'h2002, 1'b0, 2'd0, 2'd0},
        {8'hC2, 8'h00, 8'h00, 16'h2FFF, 4'd2, 1'b0, 1'b1, 2'd2, 16'h2FFF, 1'b0, 2'd0, 2'd0},
        {8'hE3, 8'h00, 8'h00, 16'h3FFE, 4'd3, 1'b0, 1'b1, 2'd3, 16'h3FFE, 1'b1, 2'd0, 2'd0},
        {8'h84, 8'h00, 8'h00, 16'h1000, 4'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h85, 8'h00, 8'h00, 16'h1005, 4'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'hA6, 8'h00, 8'h00, 16'h1FF0, 4'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h88, 8'h80, 8'h00, 16'h0F80, 4'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd1, 2'd0},
        {8'hC9, 8'h12, 8'h34, 16'h4234, 4'd4, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd2, 2'd0},
        {8'h8B, 8'h00, 8'h00, 16'h0005, 4'd4, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h8C, 8'hFE, 8'h00, 16'h7FFF, 4'd1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd1, 2'd0},
        {8'h8D, 8'h01, 8'h00, 16'h8102, 4'd5, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd2, 2'd0},
        {8'h9F, 8'h12, 8'h34, 16'hCBCA, 4'd5, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd2, 2'd2},
        {8'h94, 8'h00, 8'h00, 16'hFFFE, 4'd3, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd2},
        {8'h98, 8'h10, 8'h00, 16'hEFEE, 4'd4, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd1, 2'd2},
        {8'h87, 8'h00, 8'h00, 16'h0000, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h8F, 8'h00, 8'h00, 16'h0000, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'h90, 8'h00, 8'h00, 16'hFFFE, 4'd5, 1'b1, 1'b1, 2'd0, 16'h1001, 1'b0, 2'd0, 2'd2},
        {8'hF3, 8'h00, 8'h00, 16'h0100, 4'd6, 1'b0, 1'b1, 2'd3, 16'h3FFE, 1'b1, 2'd0, 2'd2},
        {8'h9A, 8'h00, 8'h00, 16'h0000, 4'd0, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd0, 2'd0},
        {8'hFF, 8'hFF, 8'hFF, 16'h00FF, 4'd5, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd2, 2'd2},
        {8'hDD, 8'h80, 8'h00, 16'hFDFC, 4'd8, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 2'd2, 2'd2},
        {8'hB2, 8'h00, 8'h00, 16'h00FF, 4'd5, 1'b1, 1'b1, 2'd1, 16'h1FFF, 1'b0, 2'd0, 2'd2}
    };

    initial begin
        // R13: state during reset
        repeat (3) @(negedge clk);
        chk("R13", "busy in reset", 32'(busy), 32'd0);
        chk("R13", "done in reset", 32'(done), 32'd0);
        chk("R13", "requests in reset", 32'({fetch_req, mem_rd_req}), 32'd0);
        chk("R13", "write in reset", 32'(reg_wr_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic [68:0] v;
            string t;
            v = VEC[k];
            t = tag_of(v[68:61]);
            run_op(v[68:61], v[60:53], v[52:45], (k == 11));
            chk(t, "ea", 32'(r_ea), 32'(v[44:29]));
            chk(t, "extra", 32'(r_ext), 32'(v[28:25]));
            chk("R9", "illegal flag", 32'(r_ill), 32'(v[24]));
            chk("R10", "write count", 32'(r_wr), 32'(v[23]));
            if (v[23]) begin
                chk(t, "write sel", 32'(r_wsel), 32'(v[22:21]));
                chk(t, "write data", 32'(r_wdata), 32'(v[20:5]));
                chk("R10", "nmi arm", 32'(r_nmi), 32'(v[4]));
            end
            chk("R11", "bytes fetched", 32'(r_nf), 32'(v[3:2]));
            chk("R11", "bytes read", 32'(r_nr), 32'(v[1:0]));
            if (v[3:2] == 2'd0 && v[1:0] == 2'd0) begin
                chk("R12", "direct latency", 32'(r_lat), 32'd0);
            end
        end

        // R14: wrap of write-back and short offset
        reg_x = 16'hFFFF;
        run_op(8'h81, 8'h00, 8'h00, 1'b0);
        chk("R14", "post-inc ea", 32'(r_ea), 32'h0000FFFF);
        chk("R14", "post-inc wrap", 32'(r_wdata), 32'h00000001);
        run_op(8'h01, 8'h00, 8'h00, 1'b0);
        chk("R14", "short wrap", 32'(r_ea), 32'h00000000);
        reg_x = 16'h1000;

        // R12: idle after completion, quiet outputs
        @(negedge clk);
        chk("R12", "idle after done", 32'(busy), 32'd0);

        summary();
        $finish;
    end

endmodule